// File: doc/BRIEF.md
# Mailbox Command Transaction Sequencer

This engine runs one complete request/reply exchange with a helper processor on behalf of the host. The two sides share a sixteen-word message area and two 32-bit mailbox words, all reached through one synchronous memory port of the engine. A start pulse hands the engine a command code, an argument count and a buffer of argument words. The engine then waits until the helper's outgoing mailbox is empty and builds the message in the shared area, inserting a checksum after the last argument. It rings the doorbell, waits for a nonzero reply code, copies the whole reply area back, checks the reply's checksum and frees the mailbox.

Every wait is a bounded poll. Polls are spaced by a programmable number of idle cycles and limited to a programmable count. When the limit is reached the exchange ends with a timeout code. The result is a 32-bit status word and the sixteen reply words, which are held until the next start.

Top module: `mbox_txn_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `busy_o`, `done_o`, `status_o`, `reply_o` and `mem_req_o` are all zero.
- R2: After a start, the engine reads the outgoing mailbox (address `HOST_MBX_ADDR`) until it reads zero. Successive reads are exactly `POLL_GAP`+2 cycles apart. After `POLL_LIMIT` nonzero reads the exchange ends with status 0x8000_0010, and no write is made.
- R3: The message is written as 16 writes to `MSG_BASE`+i, in increasing i. Word 0 is 1, word 1 is the command code, and word i≥3 is argument slot i−3 (bits [32(i−3)+31 : 32(i−3)] of `args_i`), except at the checksum index.
- R4: With N as the argument count carried in word 2, the word at index N+3 is the modulo-2^32 sum of words 0 through N+2.
- R5: Word 2 carries the argument count. An `arg_cnt_i` above 12 is treated as 12, both in word 2 and in the position of the checksum.
- R6: Directly after the message, the value 1 is written to the doorbell mailbox (address `COP_MBX_ADDR`).
- R7: After the doorbell, the outgoing mailbox is read until it is nonzero, with the same spacing and limit as in R2. On exhaustion the status is 0x8000_0010, `reply_o` stays all zero, and the release of R10 is still made.
- R8: On a nonzero response the 16 message words are read at `MSG_BASE`+i in increasing i. `reply_o` bits [32i+31:32i] then hold word i.
- R9: With K as reply word 2: if K>12, or if the sum of reply words 0..K+2 differs from reply word K+3, the status is 0x8000_0004. Otherwise the status is the response code as read (1 means success; an error word such as 0x8000_0002 is passed unchanged).
- R10: After a response or a response timeout, a zero is written to `HOST_MBX_ADDR` if the version latched at start is below 2, and to `COP_MBX_ADDR` otherwise. This is the last access of the exchange.
- R11: `busy_o` rises on the cycle after an accepted start and stays high through the single-cycle `done_o` pulse. A start while `busy_o` is high changes neither the access sequence nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cmd_i | input | DATA_W | Command code for word 1 |
| arg_cnt_i | input | $clog2(MSG_WORDS) | Argument count, clamped to MSG_WORDS−4 |
| args_i | input | (MSG_WORDS−3)·DATA_W | Argument buffer, slot j for word j+3 |
| proto_ver_i | input | VER_W | Protocol version, selects the release mailbox |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle end-of-exchange pulse |
| status_o | output | DATA_W | Result code |
| reply_o | output | MSG_WORDS·DATA_W | Reply words read back |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after a read request |

## Verification
A wrong sequencing state shows up on the memory port within one access. It appears as a write to the wrong address, a misplaced or miscounted checksum word, a missing doorbell, or a release sent to the wrong mailbox. The bench therefore compares every port access against an independently built expected list, one entry per clock in which a request is made. A poll counter or gap counter that is off by one shows up at the next poll, as a changed spacing or an extra or missing poll before the timeout. A wrong reply check or wrong classification shows only at the done pulse, in the status word and the reply bus.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE_RD,
    S_PRE_CHK,
    S_PRE_WAIT,
    S_WR,
    S_BELL,
    S_RSP_RD,
    S_RSP_CHK,
    S_RSP_WAIT,
    S_RD_REQ,
    S_RD_CAP,
    S_VERIFY,
    S_JUDGE,
    S_REL,
    S_DONE
  } seq_state_e;

  localparam logic [31:0] HDR_CMD     = 32'h0000_0001;
  localparam logic [31:0] ERR_FLAG    = 32'h8000_0000;
  localparam logic [31:0] ST_BAD_CSUM = ERR_FLAG | 32'h0000_0004;
  localparam logic [31:0] ST_TIMEOUT  = ERR_FLAG | 32'h0000_0010;
  localparam logic [31:0] BELL_VALUE  = 32'h0000_0001;

endpackage

// File: rtl/mbx_msg_word.sv
module mbx_msg_word #(
  parameter int DATA_W    = 32,
  parameter int MSG_WORDS = 16,
  parameter int IDX_W     = $clog2(MSG_WORDS)
) (
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [DATA_W-1:0]                cmd_i,
  input  logic [IDX_W-1:0]                 cnt_i,
  input  logic [(MSG_WORDS-3)*DATA_W-1:0]  args_i,
  input  logic [DATA_W-1:0]                csum_i,
  output logic [DATA_W-1:0]                word_o,
  output logic                             sum_en_o
);
  import mbx_seq_pkg::*;

  localparam int PW = IDX_W + 1;

  logic [DATA_W-1:0] frame [MSG_WORDS];
  logic [PW-1:0]     csum_pos;

  // Fixed part of the frame and the argument slots
  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_frame
    if (g == 0) begin : g_hdr
      assign frame[g] = DATA_W'(HDR_CMD);
    end else if (g == 1) begin : g_cmd
      assign frame[g] = cmd_i;
    end else if (g == 2) begin : g_cnt
      assign frame[g] = DATA_W'(cnt_i);
    end else begin : g_arg
      assign frame[g] = args_i[(g-3)*DATA_W +: DATA_W];
    end
  end

  assign csum_pos = {1'b0, cnt_i} + PW'(3);

  always_comb begin
    if ({1'b0, idx_i} == csum_pos) begin
      word_o = csum_i;
    end else begin
      word_o = frame[idx_i];
    end
    sum_en_o = ({1'b0, idx_i} < csum_pos);
  end

endmodule

// File: rtl/mbx_csum_acc.sv
module mbx_csum_acc #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] sum_o
);

  logic [DATA_W-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr_i) begin
      sum_d = '0;
    end else if (add_i) begin
      sum_d = sum_q + word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !add_i) |=> $stable(sum_o)); // R4

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sum_o == '0)); // R4

endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic miss_i,
  output logic last_o,
  output logic gap_done_o
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(POLL_LIMIT - 1);
  localparam logic [GAP_W-1:0] LAST_GAP  = GAP_W'(POLL_GAP - 1);

  logic [CNT_W-1:0] poll_q, poll_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             run_q, run_d;

  always_comb begin
    poll_d = poll_q;
    gap_d  = gap_q;
    run_d  = run_q;
    if (clr_i) begin
      poll_d = '0;
      gap_d  = '0;
      run_d  = 1'b0;
    end else if (miss_i) begin
      poll_d = poll_q + CNT_W'(1);
      gap_d  = '0;
      run_d  = 1'b1;
    end else if (run_q) begin
      if (gap_q == LAST_GAP) begin
        run_d = 1'b0;
      end else begin
        gap_d = gap_q + GAP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= '0;
      gap_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      poll_q <= poll_d;
      gap_q  <= gap_d;
      run_q  <= run_d;
    end
  end

  assign last_o     = (poll_q == LAST_POLL);
  assign gap_done_o = run_q && (gap_q == LAST_GAP);

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= LAST_POLL); // R2

  AST_NO_MISS_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |-> !run_q); // R7

endmodule

// File: rtl/mbox_txn_seq.sv
module mbox_txn_seq #(
  parameter int DATA_W    = 32,
  parameter int MSG_WORDS = 16,
  parameter int ADDR_W    = 8,
  parameter int VER_W     = 4,
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 3,
  parameter logic [ADDR_W-1:0] MSG_BASE      = 8'h40,
  parameter logic [ADDR_W-1:0] COP_MBX_ADDR  = 8'h04,
  parameter logic [ADDR_W-1:0] HOST_MBX_ADDR = 8'h05
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [DATA_W-1:0]                 cmd_i,
  input  logic [$clog2(MSG_WORDS)-1:0]      arg_cnt_i,
  input  logic [(MSG_WORDS-3)*DATA_W-1:0]   args_i,
  input  logic [VER_W-1:0]                  proto_ver_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [DATA_W-1:0]                 status_o,
  output logic [MSG_WORDS*DATA_W-1:0]       reply_o,
  output logic                              mem_req_o,
  output logic                              mem_we_o,
  output logic [ADDR_W-1:0]                 mem_addr_o,
  output logic [DATA_W-1:0]                 mem_wdata_o,
  input  logic [DATA_W-1:0]                 mem_rdata_i
);
  import mbx_seq_pkg::*;

  localparam int IDX_W     = $clog2(MSG_WORDS);
  localparam int PW        = IDX_W + 1;
  localparam int ARG_WORDS = MSG_WORDS - 3;
  localparam int MAX_ARGS  = MSG_WORDS - 4;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_WORDS - 1);
  localparam logic [IDX_W-1:0] MAX_CNT  = IDX_W'(MAX_ARGS);

  seq_state_e state_q, state_d;
  logic [IDX_W-1:0]            idx_q, idx_d;
  logic [DATA_W-1:0]           cmd_q, cmd_d;
  logic [IDX_W-1:0]            cnt_q, cnt_d;
  logic [ARG_WORDS*DATA_W-1:0] args_q, args_d;
  logic [VER_W-1:0]            ver_q, ver_d;
  logic [DATA_W-1:0]           resp_q, resp_d;
  logic [DATA_W-1:0]           status_q, status_d;
  logic [DATA_W-1:0]           reply_q [MSG_WORDS];
  logic [DATA_W-1:0]           reply_d [MSG_WORDS];

  // Shared helpers
  logic [DATA_W-1:0] tx_word;
  logic              tx_sum_en;
  logic              acc_clr, acc_add;
  logic [DATA_W-1:0] acc_word, acc_sum;
  logic              tmr_clr, tmr_miss, tmr_last, tmr_gap_done;

  // Reply checksum window
  logic [DATA_W-1:0] rx_cnt;
  logic              rx_cnt_ok;
  logic [PW-1:0]     rx_pos;
  logic              rx_sum_en;
  logic              rx_bad;

  logic [IDX_W-1:0]  cnt_in;
  logic              last_word;
  logic              rel_to_host;

  assign cnt_in      = (arg_cnt_i > MAX_CNT) ? MAX_CNT : arg_cnt_i;
  assign last_word   = (idx_q == LAST_IDX);
  assign rel_to_host = (ver_q < VER_W'(2));

  assign rx_cnt    = reply_q[2];
  assign rx_cnt_ok = (rx_cnt <= DATA_W'(MAX_ARGS));
  assign rx_pos    = {1'b0, rx_cnt[IDX_W-1:0]} + PW'(3);
  assign rx_sum_en = rx_cnt_ok && ({1'b0, idx_q} < rx_pos);
  assign rx_bad    = !rx_cnt_ok || (acc_sum != reply_q[rx_pos[IDX_W-1:0]]);

  mbx_msg_word #(
    .DATA_W    (DATA_W),
    .MSG_WORDS (MSG_WORDS),
    .IDX_W     (IDX_W)
  ) u_msg_word (
    .idx_i    (idx_q),
    .cmd_i    (cmd_q),
    .cnt_i    (cnt_q),
    .args_i   (args_q),
    .csum_i   (acc_sum),
    .word_o   (tx_word),
    .sum_en_o (tx_sum_en)
  );

  mbx_csum_acc #(
    .DATA_W (DATA_W)
  ) u_csum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (acc_clr),
    .add_i  (acc_add),
    .word_i (acc_word),
    .sum_o  (acc_sum)
  );

  mbx_poll_timer #(
    .POLL_LIMIT (POLL_LIMIT),
    .POLL_GAP   (POLL_GAP)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (tmr_clr),
    .miss_i     (tmr_miss),
    .last_o     (tmr_last),
    .gap_done_o (tmr_gap_done)
  );

  // Helper control
  always_comb begin
    acc_clr  = (state_q == S_IDLE) || ((state_q == S_RD_CAP) && last_word);
    acc_add  = 1'b0;
    acc_word = tx_word;
    if (state_q == S_WR) begin
      acc_add  = tx_sum_en;
      acc_word = tx_word;
    end else if (state_q == S_VERIFY) begin
      acc_add  = rx_sum_en;
      acc_word = reply_q[idx_q];
    end
    tmr_clr  = (state_q == S_IDLE) || (state_q == S_BELL);
    tmr_miss = ((state_q == S_PRE_CHK) && (mem_rdata_i != '0) && !tmr_last) ||
               ((state_q == S_RSP_CHK) && (mem_rdata_i == '0) && !tmr_last);
  end

  // Next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cmd_d    = cmd_q;
    cnt_d    = cnt_q;
    args_d   = args_q;
    ver_d    = ver_q;
    resp_d   = resp_q;
    status_d = status_q;
    reply_d  = reply_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          cmd_d    = cmd_i;
          cnt_d    = cnt_in;
          args_d   = args_i;
          ver_d    = proto_ver_i;
          resp_d   = '0;
          status_d = '0;
          idx_d    = '0;
          for (int i = 0; i < MSG_WORDS; i++) reply_d[i] = '0;
          state_d  = S_PRE_RD;
        end
      end
      S_PRE_RD:   state_d = S_PRE_CHK;
      S_PRE_CHK: begin
        if (mem_rdata_i == '0) begin
          idx_d   = '0;
          state_d = S_WR;
        end else if (tmr_last) begin
          status_d = DATA_W'(ST_TIMEOUT);
          state_d  = S_DONE;
        end else begin
          state_d = S_PRE_WAIT;
        end
      end
      S_PRE_WAIT: if (tmr_gap_done) state_d = S_PRE_RD;
      S_WR: begin
        idx_d = idx_q + IDX_W'(1);
        if (last_word) begin
          idx_d   = '0;
          state_d = S_BELL;
        end
      end
      S_BELL:     state_d = S_RSP_RD;
      S_RSP_RD:   state_d = S_RSP_CHK;
      S_RSP_CHK: begin
        if (mem_rdata_i != '0) begin
          resp_d  = mem_rdata_i;
          idx_d   = '0;
          state_d = S_RD_REQ;
        end else if (tmr_last) begin
          status_d = DATA_W'(ST_TIMEOUT);
          state_d  = S_REL;
        end else begin
          state_d = S_RSP_WAIT;
        end
      end
      S_RSP_WAIT: if (tmr_gap_done) state_d = S_RSP_RD;
      S_RD_REQ:   state_d = S_RD_CAP;
      S_RD_CAP: begin
        reply_d[idx_q] = mem_rdata_i;
        if (last_word) begin
          idx_d   = '0;
          state_d = S_VERIFY;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = S_RD_REQ;
        end
      end
      S_VERIFY: begin
        idx_d = idx_q + IDX_W'(1);
        if (last_word) begin
          idx_d   = '0;
          state_d = S_JUDGE;
        end
      end
      S_JUDGE: begin
        status_d = rx_bad ? DATA_W'(ST_BAD_CSUM) : resp_q;
        state_d  = S_REL;
      end
      S_REL:      state_d = S_DONE;
      S_DONE:     state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      cmd_q    <= '0;
      cnt_q    <= '0;
      args_q   <= '0;
      ver_q    <= '0;
      resp_q   <= '0;
      status_q <= '0;
      for (int i = 0; i < MSG_WORDS; i++) reply_q[i] <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      cmd_q    <= cmd_d;
      cnt_q    <= cnt_d;
      args_q   <= args_d;
      ver_q    <= ver_d;
      resp_q   <= resp_d;
      status_q <= status_d;
      reply_q  <= reply_d;
    end
  end

  // Memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = HOST_MBX_ADDR;
    mem_wdata_o = '0;
    unique case (state_q)
      S_PRE_RD, S_RSP_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = HOST_MBX_ADDR;
      end
      S_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = MSG_BASE + ADDR_W'(idx_q);
        mem_wdata_o = tx_word;
      end
      S_BELL: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = COP_MBX_ADDR;
        mem_wdata_o = DATA_W'(BELL_VALUE);
      end
      S_RD_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = MSG_BASE + ADDR_W'(idx_q);
      end
      S_REL: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = rel_to_host ? HOST_MBX_ADDR : COP_MBX_ADDR;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_reply
    assign reply_o[g*DATA_W +: DATA_W] = reply_q[g];
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign status_o = status_q;

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o != '0)); // R9

  AST_BELL_WRITE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && (mem_addr_o == COP_MBX_ADDR)) |->
      ((mem_wdata_o == DATA_W'(BELL_VALUE)) || (mem_wdata_o == '0))); // R6

  AST_REL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && (mem_wdata_o == '0) &&
     ((mem_addr_o == HOST_MBX_ADDR) || (mem_addr_o == COP_MBX_ADDR))) |=> done_o); // R10

endmodule

// File: tb/mbox_txn_seq_tb_top.sv
module mbox_txn_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 1000;
  localparam int GAP        = 3;
  localparam int NW         = 16;
  localparam int EXP_DEPTH  = 2200;
  localparam logic [7:0] BASE_A = 8'h40;
  localparam logic [7:0] COP_A  = 8'h04;
  localparam logic [7:0] HOST_A = 8'h05;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   cmd_i = '0;
  logic [3:0]    arg_cnt_i = '0;
  logic [415:0]  args_i = '0;
  logic [3:0]    proto_ver_i = '0;
  logic          busy_o, done_o;
  logic [31:0]   status_o;
  logic [511:0]  reply_o;
  logic          mem_req_o, mem_we_o;
  logic [7:0]    mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic [31:0]   mem_rdata_i = '0;

  mbox_txn_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmd_i       (cmd_i),
    .arg_cnt_i   (arg_cnt_i),
    .args_i      (args_i),
    .proto_ver_i (proto_ver_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .reply_o     (reply_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Scenario configuration (written by the main process only)
  int          cfg_pre_busy;
  int          cfg_rsp_delay;
  logic [31:0] cfg_resp;
  logic [31:0] t_args  [13];
  logic [31:0] t_reply [NW];

  // Expected access list: {kind, we, addr, data}
  logic [44:0] exp_mem [EXP_DEPTH];
  int          exp_n;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;

  // Helper processor model
  int   pre_cnt, rsp_cnt;
  logic rung;
  always @(posedge clk) begin
    if (start_i && !busy_o) begin
      pre_cnt <= 0;
      rsp_cnt <= 0;
      rung    <= 1'b0;
    end
    if (mem_req_o) begin
      if (mem_we_o) begin
        if (mem_addr_o == COP_A && mem_wdata_o == 32'd1) rung <= 1'b1;
      end else if (mem_addr_o == HOST_A) begin
        if (!rung) begin
          mem_rdata_i <= (pre_cnt < cfg_pre_busy) ? 32'hBEEF_0001 : 32'd0;
          pre_cnt     <= pre_cnt + 1;
        end else begin
          mem_rdata_i <= (rsp_cnt < cfg_rsp_delay) ? 32'd0 : cfg_resp;
          rsp_cnt     <= rsp_cnt + 1;
        end
      end else if (mem_addr_o >= BASE_A && mem_addr_o < BASE_A + 8'd16) begin
        mem_rdata_i <= t_reply[mem_addr_o - BASE_A];
      end else begin
        mem_rdata_i <= 32'hDEAD_DEAD;
      end
    end
  end

  // Per-clock comparison of port accesses against the expected list
  int exp_idx  = 0;
  int cyc      = 0;
  int last_pol = -1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && mem_req_o) begin
      mon_checks = mon_checks + 1;
      if (exp_idx >= exp_n) begin
        mon_errors = mon_errors + 1;
        $display("FAIL R11 unexpected access: act we=%0b addr=%h data=%h exp none",
                 mem_we_o, mem_addr_o, mem_wdata_o);
      end else begin
        logic [44:0] e;
        e = exp_mem[exp_idx];
        if (e[40] != mem_we_o || e[39:32] != mem_addr_o ||
            (e[40] && e[31:0] != mem_wdata_o)) begin
          mon_errors = mon_errors + 1;
          $display("FAIL R%0d access %0d: act we=%0b addr=%h data=%h exp we=%0b addr=%h data=%h",
                   e[44:41], exp_idx, mem_we_o, mem_addr_o, mem_wdata_o,
                   e[40], e[39:32], e[31:0]);
        end
        exp_idx = exp_idx + 1;
      end
      if (!mem_we_o && mem_addr_o == HOST_A) begin
        if (last_pol >= 0) begin
          mon_checks = mon_checks + 1;
          if (cyc - last_pol != GAP + 2) begin
            mon_errors = mon_errors + 1;
            $display("FAIL %s poll spacing: act %0d exp %0d",
                     rung ? "R7" : "R2", cyc - last_pol, GAP + 2);
          end
        end
        last_pol = cyc;
      end else begin
        last_pol = -1;
      end
    end
    if (rst_n && done_o) begin
      mon_checks = mon_checks + 1;
      if (exp_idx != exp_n) begin
        mon_errors = mon_errors + 1;
        $display("FAIL R10 access count at done: act %0d exp %0d", exp_idx, exp_n);
      end
      exp_idx  = 0;
      last_pol = -1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic we, input logic [7:0] a, input logic [31:0] d);
    exp_mem[exp_n] = {4'(kind), we, a, d};
    exp_n = exp_n + 1;
  endtask

  // Reply builder: K in word 2, checksum at K+3 when K <= 12
  task automatic make_reply(input logic [31:0] k, input logic [31:0] seed, input bit corrupt);
    logic [31:0] s;
    t_reply[0] = 32'd2;
    t_reply[1] = seed;
    t_reply[2] = k;
    for (int i = 3; i < NW; i++) t_reply[i] = seed ^ (32'h0101_0101 * i) ^ 32'h5A00_0000;
    if (k <= 12) begin
      s = 0;
      for (int i = 0; i < k + 3; i++) s = s + t_reply[i];
      t_reply[k + 3] = corrupt ? s + 32'd1 : s;
    end
  endtask

  task automatic run(input string name, input logic [31:0] cmd, input int cnt,
                     input int ver, input int pre_busy, input int rsp_delay,
                     input logic [31:0] resp, input bit extra_start);
    int          n, k, npre, nrsp, waited;
    logic [31:0] w [NW];
    logic [31:0] s, exp_status;
    bit          idle_to, rsp_to, busy_drop;

    cfg_pre_busy  = pre_busy;
    cfg_rsp_delay = rsp_delay;
    cfg_resp      = resp;
    n = (cnt > 12) ? 12 : cnt;
    w[0] = 32'd1; w[1] = cmd; w[2] = n;
    for (int i = 3; i < NW; i++) w[i] = t_args[i-3];
    s = 0;
    for (int i = 0; i < n + 3; i++) s = s + w[i];
    w[n+3] = s;

    exp_n   = 0;
    idle_to = (pre_busy >= LIMIT);
    rsp_to  = (rsp_delay >= LIMIT);
    npre    = idle_to ? LIMIT : pre_busy + 1;
    for (int i = 0; i < npre; i++) push(2, 1'b0, HOST_A, 32'd0);
    if (idle_to) begin
      exp_status = 32'h8000_0010;
    end else begin
      for (int i = 0; i < NW; i++)
        push((i == n + 3) ? 4 : (i == 2) ? 5 : 3, 1'b1, BASE_A + 8'(i), w[i]);
      push(6, 1'b1, COP_A, 32'd1);
      nrsp = rsp_to ? LIMIT : rsp_delay + 1;
      for (int i = 0; i < nrsp; i++) push(7, 1'b0, HOST_A, 32'd0);
      if (rsp_to) begin
        exp_status = 32'h8000_0010;
      end else begin
        for (int i = 0; i < NW; i++) push(8, 1'b0, BASE_A + 8'(i), 32'd0);
        k = int'(t_reply[2]);
        if (t_reply[2] > 32'd12) begin
          exp_status = 32'h8000_0004;
        end else begin
          s = 0;
          for (int i = 0; i < k + 3; i++) s = s + t_reply[i];
          exp_status = (s != t_reply[k+3]) ? 32'h8000_0004 : resp;
        end
      end
      push(10, 1'b1, (ver < 2) ? HOST_A : COP_A, 32'd0);
    end

    @(negedge clk);
    start_i     = 1'b1;
    cmd_i       = cmd;
    arg_cnt_i   = 4'(cnt);
    proto_ver_i = 4'(ver);
    for (int i = 0; i < 13; i++) args_i[i*32 +: 32] = t_args[i];
    @(negedge clk);
    start_i = 1'b0;
    check({name, " R11 busy after start"}, {31'd0, busy_o}, 32'd1);

    waited    = 0;
    busy_drop = 0;
    while (!done_o) begin
      @(negedge clk);
      waited = waited + 1;
      if (!busy_o) busy_drop = 1;
      if (extra_start && waited == 20) begin
        start_i = 1'b1; cmd_i = 32'hFFFF_0000; arg_cnt_i = 4'd2; proto_ver_i = 4'(3 - ver);
      end else begin
        start_i = 1'b0;
      end
    end
    check({name, " R11 busy held until done"}, {31'd0, busy_drop}, 32'd0);
    check({name, idle_to ? " R2 status" : rsp_to ? " R7 status" : " R9 status"},
          status_o, exp_status);
    for (int i = 0; i < NW; i++)
      check({name, " R8 reply word"}, reply_o[i*32 +: 32],
            (idle_to || rsp_to) ? 32'd0 : t_reply[i]);
    @(negedge clk);
    check({name, " R11 done is one cycle"}, {31'd0, done_o}, 32'd0);
    check({name, " R11 idle after done"}, {31'd0, busy_o}, 32'd0);
    repeat (8) @(negedge clk);
    check({name, " R11 stays idle"}, {31'd0, busy_o}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    $display("FAIL watchdog expired: act running exp finished");
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  initial begin : main
    exp_n = 0;
    cfg_pre_busy = 0; cfg_rsp_delay = 0; cfg_resp = 32'd1;
    for (int i = 0; i < 13; i++) t_args[i] = 32'h1000_0000 + 32'(i * 7);
    for (int i = 0; i < NW; i++) t_reply[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy_o}, 32'd0);
    check("R1 req in reset", {31'd0, mem_req_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 done", {31'd0, done_o}, 32'd0);
    check("R1 status", status_o, 32'd0);
    check("R1 reply", reply_o[31:0] | reply_o[511:480], 32'd0);
    check("R1 req", {31'd0, mem_req_o}, 32'd0);

    // R3 R4 R6 R8 R9 R10: one argument, version 3, busy helper at first
    t_args[0] = 32'd1;
    make_reply(32'd3, 32'h0000_0101, 1'b0);
    run("success_v3", 32'h0000_0101, 1, 3, 2, 3, 32'd1, 1'b0);

    // R10: version 1 releases the outgoing mailbox; no arguments
    make_reply(32'd5, 32'h0000_0202, 1'b0);
    run("success_v1", 32'h0000_0202, 0, 1, 0, 0, 32'd1, 1'b0);

    // R9: checksum mismatch in the reply
    t_args[0] = 32'hCAFE_0000; t_args[1] = 32'hFFFF_FFFF;
    make_reply(32'd2, 32'h0000_0303, 1'b1);
    run("bad_csum", 32'h0000_0303, 2, 2, 1, 2, 32'd1, 1'b0);

    // R9: reply count beyond the message
    make_reply(32'd13, 32'h0000_0404, 1'b0);
    run("bad_count", 32'h0000_0404, 3, 0, 0, 1, 32'd1, 1'b0);

    // R9: error word from the helper passes unchanged
    make_reply(32'd12, 32'h0000_0505, 1'b0);
    run("helper_err", 32'h0000_0505, 4, 3, 0, 0, 32'h8000_0002, 1'b0);

    // R5 R11: count clamp and start while busy
    for (int i = 0; i < 13; i++) t_args[i] = 32'hF000_0000 | 32'(i);
    make_reply(32'd0, 32'h0000_0606, 1'b0);
    run("clamp_extra_start", 32'h0000_0606, 15, 2, 0, 4, 32'd1, 1'b1);

    // R2: helper never idle
    make_reply(32'd0, 32'h0000_0707, 1'b0);
    run("idle_timeout", 32'h0000_0707, 1, 3, LIMIT, 0, 32'd1, 1'b0);

    // R7: helper never answers, version 0
    make_reply(32'd1, 32'h0000_0808, 1'b0);
    run("resp_timeout", 32'h0000_0808, 1, 0, 0, 5000, 32'd1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks, errors + mon_errors);
    $finish;
  end

endmodule